// File: doc/BRIEF.md
# Two-Dimensional Indexed Address Sequencer

This block walks the address sequence for one side, read or write, of a two-dimensional memory transfer. A transfer is made of frames, and each frame holds a fixed number of elements. On a start pulse the sequencer takes its configuration into internal registers: base address, element width, element and frame counts, signed element and frame adjustments, and the walk mode. It then offers one byte address per element on a valid/ready handshake.

In the double-indexed walk, each adjustment is added on top of the natural element-width step. It is not a plain stride. Either adjustment can be negative, so one engine can walk a framebuffer rotated, mirrored or with a padded line pitch. Each offered address carries a flag that marks the last element of its frame and a flag that marks the last element of the whole transfer. After the final element is accepted, the sequencer returns to idle.

Top module: `dix_addr_gen`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `addr_valid`, `end_of_frame` and `end_of_block` are low.
- R2: A `start` pulse while idle captures the configuration. On the next cycle `addr_valid` is high and `addr_out` equals `{base_hi, base_lo}`.
- R3: The sequence advances only on a cycle where `addr_valid` and `addr_ready` are both high. Otherwise `addr_out` and both flags hold their values.
- R4: `size_code` sets the element width in bytes: 0 gives 1, 1 gives 2, 2 gives 4, and the spare code 3 also gives 4.
- R5: Walk mode 0 keeps the same address for every element of the transfer.
- R6: Walk mode 1 adds the element width at every step, including steps across a frame boundary.
- R7: Walk mode 2 adds the sign-extended 16-bit `elem_idx` at every step, including steps across a frame boundary.
- R8: In walk mode 3, a step between two elements of the same frame adds width + `elem_idx` − 1, with `elem_idx` taken as signed.
- R9: In walk mode 3, the step after the last element of a frame adds width + F − 1. F is the signed 32-bit value `{fidx_hi, fidx_lo}`.
- R10: `end_of_frame` is high with the last element of every frame. `end_of_block` is high only with the last element of the last frame. Once that element is accepted, `addr_valid` falls on the next cycle.
- R11: An element count or a frame count of zero is treated as one.
- R12: All address arithmetic wraps modulo 2^32.
- R13: While a transfer runs, `start` and every configuration input are ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only while idle |
| base_hi | input | 16 | Upper half of the first address |
| base_lo | input | 16 | Lower half of the first address |
| size_code | input | 2 | Element width code |
| elem_cnt | input | 16 | Elements per frame (0 means 1) |
| frame_cnt | input | 16 | Frames per transfer (0 means 1) |
| elem_idx | input | 16 | Signed element adjustment |
| fidx_hi | input | 16 | Upper half of the signed frame adjustment |
| fidx_lo | input | 16 | Lower half of the signed frame adjustment |
| addr_mode | input | 2 | Walk mode: 0 hold, 1 width step, 2 index step, 3 double-indexed |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | An address is on offer |
| addr_out | output | 32 | Current byte address |
| end_of_frame | output | 1 | Current element closes its frame |
| end_of_block | output | 1 | Current element closes the transfer |

## Verification
The assertions assume that the configuration only matters in the cycle `start` is taken while idle. They also assume `addr_ready` may drop at any time, including while an address is on offer, and that all inputs are free of unknown values once reset ends. The stimulus changes inputs only on the falling clock edge. It toggles `addr_ready` irregularly and raises `start` with altered configuration in the middle of a running transfer. Every walk mode runs with small counts, so frame ends, negative adjustments and the 32-bit wrap all appear within a short run.

// File: rtl/dix_pkg.sv
package dix_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_STEP = 2'd1,
    AM_ELEM = 2'd2,
    AM_DUAL = 2'd3
  } amode_e;

  // width code -> bytes per element; spare code 3 maps to 4 bytes
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    unit_bytes = 3'd1;
      2'd1:    unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dix_span_ctr.sv
// Position counter for one dimension of the walk, with a registered
// last-position flag so the flag costs no compare in the output path.
module dix_span_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] count,
  input  logic         adv,
  output logic         last
);
  logic [W-1:0] pos_q;
  logic [W-1:0] lim_q;
  logic         last_q;
  logic [W-1:0] pos_nx;
  logic [W-1:0] lim_in;

  // zero count behaves as a single position
  assign lim_in = (count == '0) ? '0 : count - W'(1);
  assign pos_nx = pos_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      lim_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      pos_q  <= '0;
      lim_q  <= lim_in;
      last_q <= (lim_in == '0);
    end else if (adv) begin
      if (last_q) begin
        pos_q  <= '0;
        last_q <= (lim_q == '0);
      end else begin
        pos_q  <= pos_nx;
        last_q <= (pos_nx == lim_q);
      end
    end
  end

  assign last = last_q;
endmodule

// File: rtl/dix_step_sel.sv
// Picks the address increment for the next element from the latched
// walk configuration.
module dix_step_sel
  import dix_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  amode_e        mode,
  input  logic [1:0]    size_code,
  input  logic [IW-1:0] elem_idx,
  input  logic [AW-1:0] frame_idx,
  input  logic          at_frame_end,
  output logic [AW-1:0] step
);
  logic [AW-1:0] es_x;
  logic [AW-1:0] ei_x;
  logic [AW-1:0] adj;

  assign es_x = AW'(unit_bytes(size_code));
  assign ei_x = {{(AW-IW){elem_idx[IW-1]}}, elem_idx};
  assign adj  = at_frame_end ? frame_idx : ei_x;

  always_comb begin
    case (mode)
      AM_HOLD: step = '0;
      AM_STEP: step = es_x;
      AM_ELEM: step = ei_x;
      default: step = es_x + adj - AW'(1);
    endcase
  end
endmodule

// File: rtl/dix_addr_gen.sv
module dix_addr_gen
  import dix_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW/2-1:0] base_hi,
  input  logic [AW/2-1:0] base_lo,
  input  logic [1:0]      size_code,
  input  logic [CW-1:0]   elem_cnt,
  input  logic [CW-1:0]   frame_cnt,
  input  logic [IW-1:0]   elem_idx,
  input  logic [AW/2-1:0] fidx_hi,
  input  logic [AW/2-1:0] fidx_lo,
  input  logic [1:0]      addr_mode,
  input  logic            addr_ready,
  output logic            addr_valid,
  output logic [AW-1:0]   addr_out,
  output logic            end_of_frame,
  output logic            end_of_block
);
  logic          busy_q;
  logic [AW-1:0] addr_q;
  amode_e        mode_q;
  logic [1:0]    code_q;
  logic [IW-1:0] eidx_q;
  logic [AW-1:0] fidx_q;
  logic          launch;
  logic          fire;
  logic          e_last;
  logic          f_last;
  logic [AW-1:0] step;

  assign launch = start & ~busy_q;
  assign fire   = busy_q & addr_ready;

  dix_span_ctr #(.W(CW)) u_elem (
    .clk   (clk),
    .rst   (rst),
    .load  (launch),
    .count (elem_cnt),
    .adv   (fire),
    .last  (e_last)
  );

  dix_span_ctr #(.W(CW)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .load  (launch),
    .count (frame_cnt),
    .adv   (fire & e_last),
    .last  (f_last)
  );

  dix_step_sel #(.AW(AW), .IW(IW)) u_step (
    .mode         (mode_q),
    .size_code    (code_q),
    .elem_idx     (eidx_q),
    .frame_idx    (fidx_q),
    .at_frame_end (e_last),
    .step         (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      mode_q <= AM_HOLD;
      code_q <= '0;
      eidx_q <= '0;
      fidx_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      addr_q <= {base_hi, base_lo};
      mode_q <= amode_e'(addr_mode);
      code_q <= size_code;
      eidx_q <= elem_idx;
      fidx_q <= {fidx_hi, fidx_lo};
    end else if (fire) begin
      addr_q <= addr_q + step;
      if (e_last && f_last) busy_q <= 1'b0;
    end
  end

  assign addr_valid   = busy_q;
  assign addr_out     = addr_q;
  assign end_of_frame = busy_q & e_last;
  assign end_of_block = busy_q & e_last & f_last;
endmodule

// File: rtl/dix_addr_gen_chk.sv
module dix_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [AW/2-1:0] base_hi,
  input logic [AW/2-1:0] base_lo,
  input logic [1:0]      addr_mode,
  input logic            addr_ready,
  input logic            addr_valid,
  input logic [AW-1:0]   addr_out,
  input logic            end_of_frame,
  input logic            end_of_block
);
  logic [1:0] mode_seen;

  always_ff @(posedge clk) begin
    if (rst) mode_seen <= 2'd0;
    else if (start && !addr_valid) mode_seen <= addr_mode;
  end

  p_idle_flags_r1: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |-> (!end_of_frame && !end_of_block));

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !addr_valid) |=> (addr_valid && addr_out == $past({base_hi, base_lo})));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=>
      (addr_valid && $stable(addr_out) && $stable(end_of_frame) && $stable(end_of_block)));

  p_const_r5: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && addr_ready && !end_of_block && mode_seen == 2'd0) |=>
      (addr_out == $past(addr_out)));

  p_block_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    end_of_block |-> end_of_frame);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && addr_ready && end_of_block) |=> !addr_valid);
endmodule

bind dix_addr_gen dix_addr_gen_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .base_hi      (base_hi),
  .base_lo      (base_lo),
  .addr_mode    (addr_mode),
  .addr_ready   (addr_ready),
  .addr_valid   (addr_valid),
  .addr_out     (addr_out),
  .end_of_frame (end_of_frame),
  .end_of_block (end_of_block)
);

// File: tb/sim_dix_addr_gen.sv
module sim_dix_addr_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] base_hi = '0, base_lo = '0;
  logic [1:0]  size_code = '0;
  logic [15:0] elem_cnt = '0, frame_cnt = '0, elem_idx = '0;
  logic [15:0] fidx_hi = '0, fidx_lo = '0;
  logic [1:0]  addr_mode = '0;
  logic        addr_ready = 1'b0;
  logic        addr_valid;
  logic [31:0] addr_out;
  logic        end_of_frame, end_of_block;

  int n_chk = 0;
  int n_fail = 0;
  bit rdy_rand = 0;
  string cur_tag = "R2";

  logic [31:0] q_addr[$];
  bit          q_eof[$];
  bit          q_eob[$];

  always #(CLK_P/2) clk = ~clk;

  dix_addr_gen u0 (
    .clk(clk), .rst(rst), .start(start),
    .base_hi(base_hi), .base_lo(base_lo), .size_code(size_code),
    .elem_cnt(elem_cnt), .frame_cnt(frame_cnt), .elem_idx(elem_idx),
    .fidx_hi(fidx_hi), .fidx_lo(fidx_lo), .addr_mode(addr_mode),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr_out(addr_out),
    .end_of_frame(end_of_frame), .end_of_block(end_of_block)
  );

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: expected address list for one transfer
  task automatic plan(logic [31:0] base, int code, int ecnt, int fcnt,
                      int ei, int fi, int mode);
    int es = (code == 0) ? 1 : (code == 1) ? 2 : 4;
    int ne = (ecnt == 0) ? 1 : ecnt;
    int nf = (fcnt == 0) ? 1 : fcnt;
    logic [31:0] a = base;
    for (int f = 0; f < nf; f++) begin
      for (int e = 0; e < ne; e++) begin
        bit le = (e == ne - 1);
        int stp;
        q_addr.push_back(a);
        q_eof.push_back(le);
        q_eob.push_back(le && (f == nf - 1));
        case (mode)
          0: stp = 0;
          1: stp = es;
          2: stp = ei;
          default: stp = le ? (es + fi - 1) : (es + ei - 1);
        endcase
        a = a + 32'(stp);
      end
    end
  endtask

  task automatic step_cycle();
    @(negedge clk);
    start = 1'b0;
    if (q_addr.size() == 0) begin
      chk(addr_valid == 1'b0, "R10", "valid when done", 64'(addr_valid), 0);
    end else begin
      chk(addr_valid == 1'b1, cur_tag, "valid", 64'(addr_valid), 1);
      chk(addr_out == q_addr[0], cur_tag, "addr", 64'(addr_out), 64'(q_addr[0]));
      chk(end_of_frame == q_eof[0], "R10", "end_of_frame", 64'(end_of_frame), 64'(q_eof[0]));
      chk(end_of_block == q_eob[0], "R10", "end_of_block", 64'(end_of_block), 64'(q_eob[0]));
    end
    addr_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
    if (addr_valid && addr_ready && q_addr.size() > 0) begin
      void'(q_addr.pop_front());
      void'(q_eof.pop_front());
      void'(q_eob.pop_front());
    end
  endtask

  task automatic launch(logic [31:0] base, int code, int ecnt, int fcnt,
                        int ei, int fi, int mode, string tag);
    @(negedge clk);
    chk(addr_valid == 1'b0, "R1", "idle before launch", 64'(addr_valid), 0);
    chk(end_of_frame == 1'b0 && end_of_block == 1'b0, "R1", "idle flags",
        64'({end_of_frame, end_of_block}), 0);
    {base_hi, base_lo} = base;
    size_code = 2'(code);
    elem_cnt  = 16'(ecnt);
    frame_cnt = 16'(fcnt);
    elem_idx  = 16'(ei);
    {fidx_hi, fidx_lo} = 32'(fi);
    addr_mode = 2'(mode);
    start = 1'b1;
    cur_tag = tag;
    plan(base, code, ecnt, fcnt, ei, fi, mode);
  endtask

  task automatic drain();
    int guard = 0;
    while (q_addr.size() > 0 && guard < 4000) begin
      step_cycle();
      guard++;
    end
    if (guard >= 4000) begin
      chk(1'b0, cur_tag, "transfer hung", 64'(q_addr.size()), 0);
      q_addr.delete(); q_eof.delete(); q_eob.delete();
    end
    step_cycle();
    step_cycle();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired in %s actual=1 expected=0", cur_tag);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(addr_valid == 1'b0, "R1", "valid after reset", 64'(addr_valid), 0);
    chk(end_of_frame == 1'b0, "R1", "eof after reset", 64'(end_of_frame), 0);
    chk(end_of_block == 1'b0, "R1", "eob after reset", 64'(end_of_block), 0);

    // R2 R6 R4: width-2 stepping across frames
    launch(32'h0000_1000, 1, 3, 2, 0, 0, 1, "R6"); drain();
    // R4 byte, spare code
    launch(32'h0000_2000, 0, 4, 1, 0, 0, 1, "R4"); drain();
    launch(32'h0000_3000, 3, 3, 2, 0, 0, 1, "R4"); drain();
    // R3 with stalls, R5 constant walk
    rdy_rand = 1;
    launch(32'h1234_5678, 2, 3, 2, 99, 77, 0, "R5"); drain();
    // R7 negative element index
    launch(32'h0000_0100, 1, 3, 2, -6, 1000, 2, "R7"); drain();
    // R8 R9 double-indexed rotated walk, negative frame adjustment
    launch(32'h0004_0000, 2, 4, 3, 9, -32, 3, "R8"); drain();
    launch(32'h0004_0000, 1, 3, 3, -15, 40, 3, "R9"); drain();
    rdy_rand = 0;
    // R11 zero counts
    launch(32'h0000_0500, 2, 0, 0, 3, 3, 3, "R11"); drain();
    launch(32'h0000_0600, 0, 2, 0, 0, 0, 1, "R11"); drain();
    // R12 wrap
    launch(32'hFFFF_FFFC, 2, 3, 1, 0, 0, 1, "R12"); drain();
    launch(32'h0000_0002, 0, 2, 2, -4, -8, 3, "R12"); drain();
    // R13 start with new config mid-transfer is ignored
    rdy_rand = 1;
    launch(32'h0000_7000, 1, 4, 2, 0, 0, 1, "R13");
    step_cycle(); step_cycle(); step_cycle();
    start = 1'b1;
    {base_hi, base_lo} = 32'hDEAD_0000;
    addr_mode = 2'd0;
    size_code = 2'd0;
    elem_cnt  = 16'd1;
    drain();
    // R3 long double-indexed walk under stalls
    launch(32'h0010_0000, 1, 5, 4, 3, -100, 3, "R3"); drain();
    rdy_rand = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule